// File: doc/BRIEF.md
# Comparator-Sourced Timer Input Capture

This block is a free-running 16-bit timer with one input-capture register. The event that freezes the counter into the capture register comes either from an external capture pin or from the latched flag of analog comparator 2. Single-slope conversion uses the second source. Some other logic starts a ramp on an external capacitor. Comparator 2 trips when the ramp crosses the unknown voltage. The counter value at that instant is the conversion result.

The block holds the flag latches for two comparators. Each comparator has its own enable, and each flag is cleared by writing 1 to it. The comparators themselves are outside the block and arrive as asynchronous digital levels, so each one is re-timed through a synchroniser before edge detection. The block raises two interrupt requests, capture and analog, and reports the winner of a fixed-priority choice between them.

Software reaches the block through a small byte-wide register port. Reads return data one cycle after the read strobe.

Top module: `cmp_capture_timer`

## Requirements
- R1: After reset, the control register reads 0x00, the flag register reads 0x00, and `irq_cap`, `irq_ana` and `irq_id` are all 0.
- R2: The control register is at address 0. Its fields are: bit0 source select (1 = comparator), bit1 edge select (1 = rising), bit2 analog interrupt enable, bit3 comparator 1 enable, bit4 comparator 2 enable, and bits 6:5 conversion mode. With the source select at 0, a rising edge of the synchronised pin captures when edge select is 1. A falling edge captures when edge select is 0. The opposite edge does not capture.
- R3: With the source select at 1, a capture happens when the comparator 2 flag goes from 0 to 1, but only if edge select is 1. Activity on the pin has no effect in this setting.
- R4: Writing a conversion mode of 2 or 3 to the control register forces the source select bit to 1, whatever value was written to bit0.
- R5: A comparator flag is set only on a synchronised rising edge of its comparator input, and only while that comparator's enable bit is 1. A comparator that is already high when it is enabled does not set its flag.
- R6: The flag register is at address 1. It holds bit0 comparator 1 flag, bit1 comparator 2 flag and bit2 capture flag. Writing 1 to a bit clears that flag and writing 0 leaves it alone. If a clear and a set of the same flag fall in one cycle, the flag ends up set.
- R7: `irq_ana` is 1 exactly when the analog interrupt enable is 1 and at least one comparator flag is set. It follows the flags one cycle later.
- R8: `irq_cap` follows the capture flag. `irq_id` reports 1 when a capture request is pending, otherwise 2 when an analog request is pending, otherwise 0. A single comparator 2 event with the comparator as source and the analog interrupt enabled raises both requests. The analog request stays pending after the capture flag is cleared.
- R9: Address 2 reads the capture high byte and address 3 reads the low byte. Reading the high byte latches the low byte, so a later low-byte read returns the half that matches, even if a new capture happened in between.
- R10: The counter advances by one every clock cycle. Two captures taken N cycles apart therefore differ by N, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| cap_pin | input | 1 | External capture pin, asynchronous |
| cmp1_out | input | 1 | Comparator 1 output level, asynchronous |
| cmp2_out | input | 1 | Comparator 2 output level, asynchronous |
| irq_cap | output | 1 | Capture interrupt request |
| irq_ana | output | 1 | Analog interrupt request |
| irq_id | output | 2 | Highest-priority pending request: 0 none, 1 capture, 2 analog |

## Verification
The bench places a flag-clear write on the very cycle that a comparator edge sets the same flag. A design that let the clear win would lose that event. With the comparator as source, it checks that a falling edge select blocks the capture and that pin pulses are ignored. A design that left the pin connected, or that ignored edge select, would capture where it should not. It also checks that a mode 2 write sets the source bit, that the analog request outlives a cleared capture flag, and that `irq_id` moves from capture to analog. Finally, it takes a new capture between the high-byte and low-byte reads to expose a low byte that was not latched, and measures the spacing of two captures to catch a counter that stalls or skips.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_FLAG = 2'd1,
    A_CAPH = 2'd2,
    A_CAPL = 2'd3
  } reg_addr_e;

  // Packed MSB first: mode[6:5] en2[4] en1[3] aie[2] edge_rise[1] src_cmp[0]
  typedef struct packed {
    logic [1:0] mode;
    logic       en2;
    logic       en1;
    logic       aie;
    logic       edge_rise;
    logic       src_cmp;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_CAP  = 2'd1,
    IRQ_ANA  = 2'd2
  } irq_id_e;
endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic pol,   // 1: report rising edges, 0: falling edges
  output logic hit
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sh;
  logic         prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[MSB-1:0], din};
      prev <= sh[MSB];
    end
  end

  assign hit = pol ? (sh[MSB] & ~prev) : (~sh[MSB] & prev);

  initial begin
    assert (STAGES >= 2) else $error("synchroniser needs at least two stages");
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_stb,
  input  logic              rd_hi,
  output logic [CNT_W-1:0]  cap_q,
  output logic [DATA_W-1:0] lo_q
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cap_q <= '0;
      lo_q  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cap_stb) cap_q <= cnt;
      if (rd_hi)   lo_q  <= cap_q[DATA_W-1:0];
    end
  end

  // R10: without a capture strobe the held value does not move
  p_capture_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(cap_q));

  // R9: low-byte latch changes only on a high-byte read
  p_lo_latch_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_hi |=> $stable(lo_q));

  initial begin
    assert (CNT_W == 2 * DATA_W) else $error("capture must be two data bytes");
  end
endmodule

// File: rtl/cct_irq_prio.sv
module cct_irq_prio
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_req,
  input  logic       ana_req,
  output logic       irq_cap,
  output logic       irq_ana,
  output logic [1:0] irq_id
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_cap <= 1'b0;
      irq_ana <= 1'b0;
      irq_id  <= IRQ_NONE;
    end else begin
      irq_cap <= cap_req;
      irq_ana <= ana_req;
      if (cap_req)      irq_id <= IRQ_CAP;
      else if (ana_req) irq_id <= IRQ_ANA;
      else              irq_id <= IRQ_NONE;
    end
  end

  // R8: the analog id is only reported when capture is idle
  p_prio_order_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_id == IRQ_ANA) |-> (irq_ana && !irq_cap));

  p_cap_wins_r8: assert property (@(posedge clk) disable iff (rst)
    irq_cap |-> (irq_id == IRQ_CAP));
endmodule

// File: rtl/cmp_capture_timer.sv
module cmp_capture_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CMP     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cap_pin,
  input  logic              cmp1_out,
  input  logic              cmp2_out,
  output logic              irq_cap,
  output logic              irq_ana,
  output logic [1:0]        irq_id
);
  localparam int CAPF_BIT = NUM_CMP;

  ctrl_t               ctrl;
  ctrl_t               ctrl_wr;
  logic [NUM_CMP-1:0]  cmp_in;
  logic [NUM_CMP-1:0]  cmp_rise;
  logic [NUM_CMP-1:0]  cmp_en;
  logic [NUM_CMP-1:0]  cmp_set;
  logic [NUM_CMP-1:0]  cmp_clr;
  logic [NUM_CMP-1:0]  cmp_flag;
  logic                cap_flag;
  logic                pin_hit;
  logic                cap_trig;
  logic                wr_ctrl, wr_flag, rd_hi;
  logic [CNT_W-1:0]    cap_q;
  logic [DATA_W-1:0]   lo_q;
  logic [DATA_W-1:0]   rdata_d;
  logic                unused_wbits;

  assign cmp_in  = {cmp2_out, cmp1_out};
  assign cmp_en  = {ctrl.en2, ctrl.en1};
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_flag = wr_en && (addr == A_FLAG);
  assign rd_hi   = rd_en && (addr == A_CAPH);
  assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

  // Comparator input re-timing and flag latches
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (cmp_in[i]),
      .pol (1'b1),
      .hit (cmp_rise[i])
    );

    assign cmp_set[i] = cmp_rise[i] & cmp_en[i];
    assign cmp_clr[i] = wr_flag & wdata[i];

    always_ff @(posedge clk) begin
      if (rst)             cmp_flag[i] <= 1'b0;
      else if (cmp_set[i]) cmp_flag[i] <= 1'b1;
      else if (cmp_clr[i]) cmp_flag[i] <= 1'b0;
    end

    // R5: a flag can only rise while its comparator was enabled
    p_flag_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(cmp_flag[i]) |-> $past(cmp_en[i]));
  end

  // Capture pin re-timing; edge polarity chosen by control
  cct_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk (clk),
    .rst (rst),
    .din (cap_pin),
    .pol (ctrl.edge_rise),
    .hit (pin_hit)
  );

  // Capture source: comparator 2 flag going high, or pin edge
  always_comb begin
    if (ctrl.src_cmp)
      cap_trig = cmp_set[1] & ~cmp_flag[1] & ctrl.edge_rise;
    else
      cap_trig = pin_hit;
  end

  always_ff @(posedge clk) begin
    if (rst)                              cap_flag <= 1'b0;
    else if (cap_trig)                    cap_flag <= 1'b1;
    else if (wr_flag && wdata[CAPF_BIT])  cap_flag <= 1'b0;
  end

  // Control register; conversion modes 2 and 3 force the comparator source
  always_comb begin
    ctrl_wr = ctrl_t'(wdata[CTRL_W-1:0]);
    if (ctrl_wr.mode[1]) ctrl_wr.src_cmp = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_wr;
  end

  cct_capture #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .cap_stb (cap_trig),
    .rd_hi   (rd_hi),
    .cap_q   (cap_q),
    .lo_q    (lo_q)
  );

  cct_irq_prio u_irq (
    .clk     (clk),
    .rst     (rst),
    .cap_req (cap_flag),
    .ana_req (ctrl.aie & (|cmp_flag)),
    .irq_cap (irq_cap),
    .irq_ana (irq_ana),
    .irq_id  (irq_id)
  );

  // Registered read port
  always_comb begin
    rdata_d = '0;
    case (addr)
      A_CTRL: rdata_d[CTRL_W-1:0] = ctrl;
      A_FLAG: rdata_d[CAPF_BIT:0] = {cap_flag, cmp_flag};
      A_CAPH: rdata_d = cap_q[CNT_W-1 -: DATA_W];
      default: rdata_d = lo_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end

  // R4: comparator source is always set in conversion modes 2 and 3
  p_mode_forces_src_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.mode[1] |-> ctrl.src_cmp);

  // R3: a comparator capture needs rising-edge select
  p_cmp_cap_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_trig && ctrl.src_cmp) |-> ctrl.edge_rise);

  // R7: analog request follows enable and flags one cycle later
  p_ana_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.aie && (|cmp_flag)) |=> irq_ana);

  // R6: a capture event always leaves the capture flag set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    cap_trig |=> cap_flag);

  initial begin
    assert (NUM_CMP == 2) else $error("two comparators expected");
  end
endmodule

// File: tb/cmp_capture_timer_tb.sv
module cmp_capture_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cap_pin = 1'b0, cmp1_out = 1'b0, cmp2_out = 1'b0;
  logic       irq_cap, irq_ana;
  logic [1:0] irq_id;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmp_capture_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_pin(cap_pin), .cmp1_out(cmp1_out),
    .cmp2_out(cmp2_out), .irq_cap(irq_cap), .irq_ana(irq_ana), .irq_id(irq_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    @(negedge clk);
    cap_pin = 1'b0; cmp1_out = 1'b0; cmp2_out = 1'b0;
    idle(5);
    wr(2'd1, 8'h07);
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd1, v); check(v == 8'h00, "R1 flags", v, 0);
    check({irq_cap, irq_ana, irq_id} == 4'b0, "R1 irq", {irq_cap, irq_ana, irq_id}, 0);
  endtask

  task automatic t_pin_edges();
    logic [7:0] v;
    wr(2'd0, 8'h02);           // pin source, rising edge
    @(negedge clk) cap_pin = 1'b1; idle(5);
    rd(2'd1, v); check(v[2] == 1'b1, "R2 rise captures", v, 8'h04);
    wr(2'd1, 8'h04);
    @(negedge clk) cap_pin = 1'b0; idle(5);
    rd(2'd1, v); check(v[2] == 1'b0, "R2 fall ignored when rising", v, 0);
    wr(2'd0, 8'h00);           // falling edge
    @(negedge clk) cap_pin = 1'b1; idle(5);
    rd(2'd1, v); check(v[2] == 1'b0, "R2 rise ignored when falling", v, 0);
    @(negedge clk) cap_pin = 1'b0; idle(5);
    rd(2'd1, v); check(v[2] == 1'b1, "R2 fall captures", v, 8'h04);
    cleanup();
  endtask

  task automatic t_cmp_source();
    logic [7:0] v;
    wr(2'd0, 8'h11);           // comparator source, falling select, en2
    @(negedge clk) cmp2_out = 1'b1; idle(5);
    rd(2'd1, v);
    check(v == 8'h02, "R3 no capture without rising select", v, 8'h02);
    cleanup();
    wr(2'd0, 8'h13);           // comparator source, rising, en2
    @(negedge clk) cap_pin = 1'b1; idle(5);
    @(negedge clk) cap_pin = 1'b0; idle(5);
    rd(2'd1, v); check(v == 8'h00, "R3 pin ignored", v, 0);
    @(negedge clk) cmp2_out = 1'b1; idle(5);
    rd(2'd1, v); check(v == 8'h06, "R3 comparator capture", v, 8'h06);
    cleanup();
  endtask

  task automatic t_mode_force();
    logic [7:0] v;
    wr(2'd0, 8'h40); rd(2'd0, v); check(v == 8'h41, "R4 mode 2 forces source", v, 8'h41);
    wr(2'd0, 8'h62); rd(2'd0, v); check(v == 8'h63, "R4 mode 3 forces source", v, 8'h63);
    wr(2'd0, 8'h20); rd(2'd0, v); check(v == 8'h20, "R4 mode 1 leaves source", v, 8'h20);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    @(negedge clk) cmp1_out = 1'b1; idle(5);
    rd(2'd1, v); check(v[0] == 1'b0, "R5 disabled comparator", v, 0);
    wr(2'd0, 8'h08); idle(3);
    rd(2'd1, v); check(v[0] == 1'b0, "R5 already high at enable", v, 0);
    @(negedge clk) cmp1_out = 1'b0; idle(4);
    @(negedge clk) cmp1_out = 1'b1; idle(5);
    rd(2'd1, v); check(v[0] == 1'b1, "R5 enabled rise sets", v, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check(v[0] == 1'b1, "R6 write 0 keeps flag", v, 1);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check(v[0] == 1'b0, "R6 write 1 clears", v, 0);
    @(negedge clk) cmp1_out = 1'b0; idle(4);
    // clear write lands on the same edge that sets the flag
    @(negedge clk) cmp1_out = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(negedge clk) wr_en = 1'b0;
    idle(2);
    rd(2'd1, v); check(v[0] == 1'b1, "R6 set wins over clear", v, 1);
    cleanup();
  endtask

  task automatic t_analog_irq();
    wr(2'd0, 8'h08);
    @(negedge clk) cmp1_out = 1'b1; idle(5);
    check(irq_ana == 1'b0, "R7 masked", irq_ana, 0);
    wr(2'd0, 8'h0C); idle(2);
    check(irq_ana == 1'b1 && irq_id == 2'd2, "R7 enabled", {irq_ana, irq_id}, 3'b110);
    wr(2'd1, 8'h01); idle(2);
    check(irq_ana == 1'b0 && irq_id == 2'd0, "R7 cleared", {irq_ana, irq_id}, 0);
    cleanup();
  endtask

  task automatic t_dual_irq();
    logic [7:0] v;
    wr(2'd0, 8'h56);           // mode 2, rising, aie, en2 (source forced)
    @(negedge clk) cmp2_out = 1'b1; idle(5);
    check(irq_cap && irq_ana, "R8 both requests", {irq_cap, irq_ana}, 2'b11);
    check(irq_id == 2'd1, "R8 capture first", irq_id, 1);
    wr(2'd1, 8'h04); idle(2);
    check(!irq_cap && irq_ana && irq_id == 2'd2, "R8 analog still pending",
          {irq_cap, irq_ana, irq_id}, 4'b0110);
    rd(2'd1, v); check(v == 8'h02, "R8 comparator flag held", v, 8'h02);
    wr(2'd1, 8'h02); idle(2);
    check(irq_id == 2'd0 && !irq_ana, "R8 all serviced", {irq_ana, irq_id}, 0);
    wr(2'd0, 8'h00);
    cleanup();
  endtask

  task automatic t_capture_values();
    logic [7:0] h1, l1, h2, l2, v;
    int t1, t2;
    logic [15:0] c1, c2, diff;
    wr(2'd0, 8'h02);
    @(negedge clk) begin cap_pin = 1'b1; t1 = cyc; end
    idle(5);
    rd(2'd2, h1); rd(2'd3, l1); c1 = {h1, l1};
    @(negedge clk) cap_pin = 1'b0; idle(30);
    @(negedge clk) begin cap_pin = 1'b1; t2 = cyc; end
    idle(5);
    rd(2'd2, h2); rd(2'd3, l2); c2 = {h2, l2};
    diff = c2 - c1;
    check(diff == 16'(t2 - t1), "R10 capture spacing", diff, t2 - t1);
    // R9: new capture between high and low reads
    @(negedge clk) cap_pin = 1'b0; idle(4);
    rd(2'd2, v);
    @(negedge clk) cap_pin = 1'b1; idle(5);
    rd(2'd3, v); check(v == l2, "R9 low byte latched", v, l2);
    rd(2'd2, h1); rd(2'd3, l1);
    check({h1, l1} != c2, "R9 new capture visible", {h1, l1}, c2);
    wr(2'd0, 8'h00);
    cleanup();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pin_edges();
    t_cmp_source();
    t_mode_force();
    t_enable();
    t_analog_irq();
    t_dual_irq();
    t_capture_values();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule